// File: doc/BRIEF.md
# Node-Copy Migration Controller

This controller sits in each processing element of a toroidal array that runs a fine-grained, comparison-level pattern matcher. During a match phase the local match engine spawns new node copies, each holding one token. The controller keeps these spawned copies in a "marked" queue. When the phase ends, it halts the match engine and ships every marked copy to a neighbour over one of four serial links. If the queue fills to a threshold before the phase ends, the controller forces an early end-of-cycle. Matching then stays halted until the queue is empty, and resumes as if a fresh cycle had begun.

The first copy spawned in a cycle leaves the element tagged as the node's next generative copy. At the same moment the controller pulses a handover strobe, which tells the engine that its original copy is no longer generative.

The controller also terminates packets that arrive from the neighbours. A packet is seated locally when the element's memory manager reports enough free slots. Otherwise it is passed on through another link, and never back through the link it came in on. All outgoing traffic shares one round-robin pointer over the links, numbered north=0, east=1, south=2, west=3. Wrap-around at the array edges is a matter of wiring between elements.

Top module: `node_copy_migrator`

## Requirements
- R1: After reset, `match_halt`, `seat_valid` and `gen_handover` are low and all four `tx_line` bits are high (idle).
- R2: A spawn accepted while matching is queued as a marked copy. Its 24-bit packet carries `spawn_data` in bits 22:0. Bit 23 is 1 for the first copy spawned in the current cycle and 0 for later ones.
- R3: A `phase_end` pulse while matching raises `match_halt` at the next clock, and every queued marked copy is then transmitted. `gen_handover` pulses for one cycle at that clock only if at least one copy was spawned in the ending cycle.
- R4: When the queue holds `FORCE_TH` or more copies while matching, `match_halt` rises at the next clock without any `phase_end`. It stays high until the queue is empty and no marked copy is still on a link. It then falls, and the next spawn again counts as first in its cycle.
- R5: `spawn_valid` while `match_halt` is high is ignored: no copy is queued or later transmitted.
- R6: A valid received packet is presented on `seat_data` with a one-cycle `seat_valid` when `mem_free > SEAT_RESERVE`. Otherwise it is queued for forwarding and retransmitted unchanged.
- R7: A forwarded packet never leaves on the link it arrived on.
- R8: Each outgoing packet takes the first idle, permitted link at or after the round-robin pointer (north=0, east=1, south=2, west=3). The pointer then moves to the link after the one used, and at most one link is loaded per clock.
- R9: Serial frames are one bit per clock: an idle high line, a start bit of 0, 24 payload bits LSB first, and a stop bit of 1. A link starts no new frame before its stop bit has been sent.
- R10: A received frame whose stop bit is 0 is discarded (neither seated nor forwarded), and the receiver accepts the next frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_valid | input | 1 | Match engine created a marked copy this cycle |
| spawn_data | input | 23 | Contents of the spawned copy |
| phase_end | input | 1 | Match phase finished |
| mem_free | input | FREE_W | Free local copy slots reported by the memory manager |
| match_halt | output | 1 | Holds the match engine while marked copies drain |
| gen_handover | output | 1 | One-cycle strobe: the original generative copy steps down |
| seat_valid | output | 1 | A received packet is to be stored locally |
| seat_data | output | 24 | Payload of the packet to store |
| rx_line | input | 4 | Serial receive lines, index = link number |
| tx_line | output | 4 | Serial transmit lines, index = link number |

## Verification
Several properties are checked on every cycle by assertions:
- the halt rising after the occupancy threshold is reached;
- the halt never falling while marked copies remain queued;
- spawns having no effect while halted;
- a forwarded packet never being aimed back at its source link;
- at most one link loaded per clock, and never a link that is still busy.

Other behaviours are visible only from the bench's scenarios:
- the actual link order the round-robin pointer produces across forwarding and draining;
- the generative tag on exactly the first copy of each cycle;
- the handover strobe appearing only when something was spawned;
- the serial framing on the wire;
- frames with a bad stop bit being dropped.

// File: rtl/mig_pkg.sv
package mig_pkg;
  localparam int NLINK     = 4;
  localparam int LINK_W    = 2;
  localparam int PAYLOAD_W = 24;
  localparam int FRAME_W   = PAYLOAD_W + 2;

  typedef enum logic {PH_MATCH = 1'b0, PH_DRAIN = 1'b1} phase_e;

  typedef struct packed {
    logic              found;
    logic [LINK_W-1:0] idx;
  } link_pick_t;

  // First link at or after ptr that is neither busy nor banned.
  function automatic link_pick_t pick_link(input logic [NLINK-1:0] busy,
                                           input logic [NLINK-1:0] banned,
                                           input logic [LINK_W-1:0] ptr);
    link_pick_t r;
    r.found = 1'b0;
    r.idx   = '0;
    for (int i = 0; i < NLINK; i++) begin
      logic [LINK_W-1:0] c;
      c = ptr + LINK_W'(i);
      if (!r.found && !busy[c] && !banned[c]) begin
        r.found = 1'b1;
        r.idx   = c;
      end
    end
    return r;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [PAYLOAD_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction
endpackage

// File: rtl/mig_fifo.sv
module mig_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop_ok) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);  // R2
endmodule

// File: rtl/mig_ser_tx.sv
module mig_ser_tx
  import mig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PAYLOAD_W-1:0] data,
  output logic                 busy,
  output logic                 line
);
  logic [FRAME_W-1:0] frame;
  logic [4:0]         bit_idx;

  assign line = busy ? frame[bit_idx] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      frame   <= '1;
    end else if (busy) begin
      if (bit_idx == 5'(FRAME_W-1)) begin
        busy <= 1'b0;
      end else begin
        bit_idx <= bit_idx + 5'd1;
      end
    end else if (load) begin
      frame   <= build_frame(data);
      busy    <= 1'b1;
      bit_idx <= '0;
    end
  end

  AST_TX_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);  // R9
endmodule

// File: rtl/mig_ser_rx.sv
module mig_ser_rx
  import mig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 ack,
  output logic                 hold_valid,
  output logic [PAYLOAD_W-1:0] hold_data
);
  logic                 active;
  logic [4:0]           bit_idx;
  logic [PAYLOAD_W-1:0] shift;
  logic                 frame_ok;

  assign frame_ok = active && (bit_idx == 5'(PAYLOAD_W)) && line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      bit_idx    <= '0;
      shift      <= '0;
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else begin
      if (!active) begin
        if (!line) begin
          active  <= 1'b1;
          bit_idx <= '0;
        end
      end else if (bit_idx < 5'(PAYLOAD_W)) begin
        shift[bit_idx] <= line;
        bit_idx        <= bit_idx + 5'd1;
      end else begin
        active <= 1'b0;
      end
      if (frame_ok) begin
        hold_valid <= 1'b1;
        hold_data  <= shift;
      end else if (ack) begin
        hold_valid <= 1'b0;
      end
    end
  end

  AST_RX_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> hold_valid);  // R6
endmodule

// File: rtl/node_copy_migrator.sv
module node_copy_migrator
  import mig_pkg::*;
#(
  parameter int SLOTS        = 8,
  parameter int FORCE_TH     = 6,
  parameter int FWD_DEPTH    = 4,
  parameter int FREE_W       = 4,
  parameter int SEAT_RESERVE = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spawn_valid,
  input  logic [PAYLOAD_W-2:0] spawn_data,
  input  logic                 phase_end,
  input  logic [FREE_W-1:0]    mem_free,
  output logic                 match_halt,
  output logic                 gen_handover,
  output logic                 seat_valid,
  output logic [PAYLOAD_W-1:0] seat_data,
  input  logic [NLINK-1:0]     rx_line,
  output logic [NLINK-1:0]     tx_line
);
  localparam int MK_CW  = $clog2(SLOTS+1);
  localparam int FW_CW  = $clog2(FWD_DEPTH+1);
  localparam int FWD_W  = LINK_W + PAYLOAD_W;

  phase_e state;
  logic   first_pend;

  // marked-copy queue
  logic                 spawn_acc, mk_pop, mk_full, mk_empty;
  logic [PAYLOAD_W-1:0] mk_dout;
  logic [MK_CW-1:0]     mk_count;

  // forward queue
  logic                 fwd_push, fwd_pop, fwd_full, fwd_empty;
  logic [FWD_W-1:0]     fwd_din, fwd_dout;
  logic [FW_CW-1:0]     fwd_count;

  // named events
  logic force_hit, enter_drain, drain_done, seat_path;
  logic send_fwd, send_mk, marked_in_flight;

  // links
  logic [NLINK-1:0]     tx_busy, tx_load, tx_marked;
  logic [NLINK-1:0]     rx_valid, rx_ack;
  logic [PAYLOAD_W-1:0] rx_data [NLINK];
  logic [LINK_W-1:0]    rr_ptr, out_link, rx_sel;
  logic [PAYLOAD_W-1:0] out_payload;
  logic                 rx_any;
  link_pick_t           pick_f, pick_m;

  assign mk_empty   = (mk_count == '0);
  assign fwd_empty  = (fwd_count == '0);
  assign match_halt = (state == PH_DRAIN);

  // ---------------- spawn and phase control ----------------
  assign spawn_acc   = spawn_valid && (state == PH_MATCH) && !mk_full;
  assign force_hit   = (state == PH_MATCH) && (mk_count >= MK_CW'(FORCE_TH));
  assign enter_drain = (state == PH_MATCH) && (phase_end || force_hit);
  assign marked_in_flight = |(tx_busy & tx_marked);
  assign drain_done  = (state == PH_DRAIN) && mk_empty && !send_mk && !marked_in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= PH_MATCH;
      first_pend   <= 1'b1;
      gen_handover <= 1'b0;
    end else begin
      gen_handover <= enter_drain && (!first_pend || spawn_acc);
      if (spawn_acc) first_pend <= 1'b0;
      if (enter_drain) begin
        state <= PH_DRAIN;
      end else if (drain_done) begin
        state      <= PH_MATCH;
        first_pend <= 1'b1;
      end
    end
  end

  mig_fifo #(.W(PAYLOAD_W), .DEPTH(SLOTS)) u_marked (
    .clk(clk), .rst_n(rst_n),
    .push(spawn_acc), .din({first_pend, spawn_data}),
    .pop(mk_pop), .dout(mk_dout), .count(mk_count), .full(mk_full)
  );

  // ---------------- receive side ----------------
  genvar g;
  generate
    for (g = 0; g < NLINK; g++) begin : g_rx
      mig_ser_rx u_rx (
        .clk(clk), .rst_n(rst_n), .line(rx_line[g]), .ack(rx_ack[g]),
        .hold_valid(rx_valid[g]), .hold_data(rx_data[g])
      );
    end
  endgenerate

  always_comb begin
    rx_any = 1'b0;
    rx_sel = '0;
    for (int i = NLINK-1; i >= 0; i--) begin
      if (rx_valid[i]) begin
        rx_any = 1'b1;
        rx_sel = LINK_W'(i);
      end
    end
  end

  assign seat_path = (mem_free > FREE_W'(SEAT_RESERVE));
  assign fwd_push  = rx_any && !seat_path && !fwd_full;
  assign fwd_din   = {rx_sel, rx_data[rx_sel]};

  always_comb begin
    rx_ack = '0;
    if (rx_any && (seat_path || !fwd_full)) rx_ack[rx_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seat_valid <= 1'b0;
      seat_data  <= '0;
    end else begin
      seat_valid <= rx_any && seat_path;
      if (rx_any && seat_path) seat_data <= rx_data[rx_sel];
    end
  end

  mig_fifo #(.W(FWD_W), .DEPTH(FWD_DEPTH)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .push(fwd_push), .din(fwd_din),
    .pop(fwd_pop), .dout(fwd_dout), .count(fwd_count), .full(fwd_full)
  );

  // ---------------- dispatch ----------------
  always_comb begin
    logic [NLINK-1:0] ban;
    ban = '0;
    if (!fwd_empty) ban[fwd_dout[FWD_W-1 -: LINK_W]] = 1'b1;
    pick_f      = pick_link(tx_busy, ban, rr_ptr);
    pick_m      = pick_link(tx_busy, '0, rr_ptr);
    send_fwd    = !fwd_empty && pick_f.found;
    send_mk     = fwd_empty && (state == PH_DRAIN) && !mk_empty && pick_m.found;
    out_link    = send_fwd ? pick_f.idx : pick_m.idx;
    out_payload = send_fwd ? fwd_dout[PAYLOAD_W-1:0] : mk_dout;
  end

  assign fwd_pop = send_fwd;
  assign mk_pop  = send_mk;

  always_ff @(posedge clk) begin
    if (!rst_n) rr_ptr <= '0;
    else if (send_fwd || send_mk) rr_ptr <= out_link + LINK_W'(1);
  end

  generate
    for (g = 0; g < NLINK; g++) begin : g_tx
      assign tx_load[g] = (send_fwd || send_mk) && (out_link == LINK_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) tx_marked[g] <= 1'b0;
        else if (tx_load[g]) tx_marked[g] <= send_mk;
      end
      mig_ser_tx u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load[g]), .data(out_payload),
        .busy(tx_busy[g]), .line(tx_line[g])
      );
    end
  endgenerate

  // ---------------- assertions ----------------
  AST_HALT_ON_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_MATCH) && (mk_count >= MK_CW'(FORCE_TH))) |=> match_halt);  // R4
  AST_RESUME_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_halt) |-> (mk_count == '0));  // R4
  AST_SPAWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (match_halt && spawn_valid) |=> (mk_count <= $past(mk_count)));  // R5
  AST_FWD_NOT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    send_fwd |-> !tx_load[fwd_dout[FWD_W-1 -: LINK_W]]);  // R7
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load));  // R8
  AST_LOAD_IDLE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load & tx_busy) == '0);  // R9
endmodule

// File: tb/test_node_copy_migrator.sv
module test_node_copy_migrator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        spawn_valid;
  logic [22:0] spawn_data;
  logic        phase_end;
  logic [3:0]  mem_free;
  logic        match_halt, gen_handover, seat_valid;
  logic [23:0] seat_data;
  logic [3:0]  rx_line;
  logic [3:0]  tx_line;

  always #2.5 clk = ~clk;

  node_copy_migrator i_node_copy_migrator (
    .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_data(spawn_data),
    .phase_end(phase_end), .mem_free(mem_free), .match_halt(match_halt),
    .gen_handover(gen_handover), .seat_valid(seat_valid), .seat_data(seat_data),
    .rx_line(rx_line), .tx_line(tx_line)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // ---- frame log from the four transmit lines ----
  int          log_cnt = 0;
  int          log_link [64];
  logic [23:0] log_data [64];
  int          bad_stop = 0;
  logic        mon_act [4];
  int          mon_n   [4];
  logic [23:0] mon_sh  [4];
  int          seat_cnt = 0;
  logic [23:0] seat_last;
  int          gen_cnt = 0;

  initial for (int k = 0; k < 4; k++) begin mon_act[k] = 0; mon_n[k] = 0; mon_sh[k] = '0; end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (!mon_act[k]) begin
          if (tx_line[k] == 1'b0) begin mon_act[k] = 1; mon_n[k] = 0; end
        end else if (mon_n[k] < 24) begin
          mon_sh[k][mon_n[k]] = tx_line[k];
          mon_n[k]++;
        end else begin
          if (tx_line[k] !== 1'b1) bad_stop++;
          if (log_cnt < 64) begin log_link[log_cnt] = k; log_data[log_cnt] = mon_sh[k]; end
          log_cnt++;
          mon_act[k] = 0;
        end
      end
      if (seat_valid) begin seat_cnt++; seat_last = seat_data; end
      if (gen_handover) gen_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; spawn_valid = 0; spawn_data = '0; phase_end = 0;
    mem_free = 4'd5; rx_line = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) mon_act[k] = 0;
  endtask

  task automatic send_frame(input int lk, input logic [23:0] d, input logic stopb);
    @(negedge clk) rx_line[lk] = 1'b0;
    for (int b = 0; b < 24; b++) begin @(negedge clk) rx_line[lk] = d[b]; end
    @(negedge clk) rx_line[lk] = stopb;
    @(negedge clk) rx_line[lk] = 1'b1;
  endtask

  task automatic spawn(input logic [22:0] d);
    @(negedge clk) spawn_valid = 1; spawn_data = d;
  endtask

  // {mem_free[3:0], in_link[1:0], expect_seat, expect_out_link[1:0]}
  localparam logic [8:0] FWD_VEC [6] = '{
    {4'd5, 2'd0, 1'b1, 2'd0},
    {4'd0, 2'd0, 1'b0, 2'd1},
    {4'd1, 2'd2, 1'b0, 2'd3},
    {4'd0, 2'd3, 1'b0, 2'd0},
    {4'd2, 2'd1, 1'b1, 2'd0},
    {4'd0, 2'd1, 1'b0, 2'd2}
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    int base_log, base_seat, base_gen;
    do_reset();

    // R1 reset state
    @(negedge clk);
    check(match_halt == 0, "R1", "halt after reset", match_halt, 0);
    check(tx_line == 4'hF, "R1", "tx idle after reset", tx_line, 4'hF);
    check(seat_valid == 0 && gen_handover == 0, "R1", "strobes after reset",
          {seat_valid, gen_handover}, 0);

    // table: seat / forward decisions with round-robin link choice (R6 R7 R8)
    for (int v = 0; v < 6; v++) begin
      logic [23:0] pl;
      pl = 24'hA50000 + 24'(v * 24'h1111);
      base_log = log_cnt; base_seat = seat_cnt;
      mem_free = FWD_VEC[v][8:5];
      send_frame(int'(FWD_VEC[v][4:3]), pl, 1'b1);
      repeat (45) @(negedge clk);
      if (FWD_VEC[v][2]) begin
        check(seat_cnt == base_seat + 1 && seat_last == pl, "R6", "seated packet",
              seat_last, pl);
        check(log_cnt == base_log, "R6", "seated packet not retransmitted", log_cnt, base_log);
      end else begin
        check(seat_cnt == base_seat && log_cnt == base_log + 1, "R6", "forward count",
              log_cnt, base_log + 1);
        check(log_link[base_log] == int'(FWD_VEC[v][1:0]) && log_data[base_log] == pl,
              "R7", "forward link (R8 order)", log_link[base_log], FWD_VEC[v][1:0]);
      end
    end
    mem_free = 4'd5;

    // R10 bad stop bit dropped, receiver recovers
    base_log = log_cnt; base_seat = seat_cnt;
    send_frame(2, 24'h123456, 1'b0);
    repeat (40) @(negedge clk);
    check(seat_cnt == base_seat && log_cnt == base_log, "R10", "bad frame dropped",
          seat_cnt, base_seat);
    send_frame(2, 24'h0BEEF0, 1'b1);
    repeat (10) @(negedge clk);
    check(seat_cnt == base_seat + 1 && seat_last == 24'h0BEEF0, "R10", "recovery frame",
          seat_last, 24'h0BEEF0);

    // R2 R3 R8: natural phase end drains three copies
    do_reset();
    base_log = log_cnt; base_gen = gen_cnt;
    spawn(23'h000011); spawn(23'h000022); spawn(23'h000033);
    @(negedge clk) spawn_valid = 0; phase_end = 1;
    @(negedge clk) phase_end = 0;
    check(match_halt == 1, "R3", "halt after phase end", match_halt, 1);
    check(gen_handover == 1, "R3", "handover strobe", gen_handover, 1);
    repeat (10) @(negedge clk);
    check(match_halt == 1, "R4", "halt held while draining", match_halt, 1);
    repeat (40) @(negedge clk);
    check(match_halt == 0, "R4", "halt released", match_halt, 0);
    check(gen_cnt == base_gen + 1, "R3", "one handover pulse", gen_cnt, base_gen + 1);
    check(log_cnt == base_log + 3, "R3", "three copies sent", log_cnt, base_log + 3);
    check(log_data[base_log] == 24'h800011, "R2", "first copy generative",
          log_data[base_log], 24'h800011);
    check(log_data[base_log+1] == 24'h000022 && log_data[base_log+2] == 24'h000033,
          "R2", "later copies plain", log_data[base_log+2], 24'h000033);
    check(log_link[base_log] == 0 && log_link[base_log+1] == 1 && log_link[base_log+2] == 2,
          "R8", "drain link order", log_link[base_log+2], 2);
    check(bad_stop == 0, "R9", "stop bits high", bad_stop, 0);

    // R4 R5 forced end-of-cycle
    do_reset();
    base_log = log_cnt; base_gen = gen_cnt;
    for (int s = 0; s < 6; s++) spawn(23'(24'h100 + s));
    @(negedge clk) spawn_valid = 0;
    @(negedge clk);
    check(match_halt == 1, "R4", "forced halt", match_halt, 1);
    check(gen_handover == 1, "R4", "handover on forced end", gen_handover, 1);
    spawn(23'h007777); repeat (4) spawn(23'h007777);
    @(negedge clk) spawn_valid = 0;
    repeat (70) @(negedge clk);
    check(match_halt == 0, "R4", "resume after forced drain", match_halt, 0);
    check(log_cnt == base_log + 6, "R5", "only six copies sent", log_cnt, base_log + 6);
    check(log_link[base_log+4] == 0 && log_link[base_log+5] == 1, "R8",
          "links reused after busy (R9)", log_link[base_log+5], 1);
    base_gen = gen_cnt;
    @(negedge clk) phase_end = 1;
    @(negedge clk) phase_end = 0;
    repeat (40) @(negedge clk);
    check(log_cnt == base_log + 6, "R5", "ignored spawns never sent", log_cnt, base_log + 6);
    check(gen_cnt == base_gen, "R3", "no handover without spawn", gen_cnt, base_gen);
    spawn(23'h000055);
    @(negedge clk) spawn_valid = 0; phase_end = 1;
    @(negedge clk) phase_end = 0;
    repeat (40) @(negedge clk);
    check(log_cnt == base_log + 7 && log_data[base_log+6] == 24'h800055, "R4",
          "new cycle first copy generative", log_data[base_log+6], 24'h800055);
    check(log_link[base_log+6] == 2, "R8", "pointer continues", log_link[base_log+6], 2);
    check(bad_stop == 0, "R9", "stop bits high", bad_stop, 0);

    finish_up();
  end
endmodule